// File: doc/BRIEF.md
# Configurable Sampled Input Noise Filter

This block cleans up a single noisy timer input before the timer acts on it. The raw signal first passes through a short synchroniser. It is then sampled at a rate picked by a 4-bit filter code. The output takes a new level only after that many samples in a row have all shown the level. A sampled level that matches the current output throws away any partial run, so a glitch must persist to get through.

The same code sets both the sampling rate and the run length N. Three codes sample on every clock with N of 2, 4 or 8. The other codes sample once every 2, 4, 8, 16 or 32 pulses of a dead-time clock enable, with N between 5 and 8. The dead-time enable is produced elsewhere. Code 0 turns filtering off, and the synchronised input then reaches the output one register later. When the code changes, the run counter and the rate divider both restart from zero.

Top module: `event_filt`

## Requirements
- R1: During and right after synchronous reset the output is 0, and the stored filter code is 0, which selects pass-through.
- R2: With code 0 the output copies the input exactly three clock edges after the input changes. A one-cycle input pulse appears at the output as a one-cycle pulse.
- R3: Codes 1, 2 and 3 sample on every clock with N = 2, 4 and 8. After a steady input change the output flips at exactly edge 2+N. A run shorter than N cycles never reaches the output.
- R4: A sample equal to the current output clears the partial run. With code 3, two runs of 7 cycles separated by a single cycle at the old level leave the output unchanged.
- R5: Each code from 4 to 15 samples on every 2^k-th dead-time enable pulse, where the code sets k and N as follows: 4 gives k=1, N=6; 5 gives k=1, N=8; 6 gives k=2, N=6; 7 gives k=2, N=8; 8 gives k=3, N=6; 9 gives k=3, N=8; 10 gives k=4, N=5; 11 gives k=4, N=6; 12 gives k=4, N=8; 13 gives k=5, N=5; 14 gives k=5, N=6; 15 gives k=5, N=8. When enable pulses are spaced P clocks apart, an input change reaches the output no earlier than edge 3+(N-1)*P*2^k and no later than edge 2+N*P*2^k.
- R6: With a divided code, no samples are taken while the dead-time enable stays low, so the output holds. Once the enable resumes, a held input change goes through.
- R7: A change of filter code clears the run counter and the divider in the next cycle. With code 3 and a run 5 samples long, a switch to code 2 makes the output flip exactly at edge 12 after the input change.
- R8: The filter behaves the same way for a rising and a falling input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Raw input to be filtered |
| dts_en | input | 1 | One-cycle pulses of the dead-time clock |
| filt_code | input | 4 | Filter code that selects the sampling rate and N |
| sig_out | output | 1 | Filtered output |

## Verification
A wrong run count or an uncleared counter shows up directly as a shift in the output edge. With the per-clock codes that shift is visible at the exact edge 2+N, and the release of a run that should have been rejected is visible within a dozen cycles. A divider with the wrong phase or rate moves the output edge outside the window that R5 defines, which is at most a few hundred cycles for the slowest code. A counter that is not cleared on a code change makes the output flip earlier than edge 12 in the R7 sequence.

// File: rtl/event_filt_pkg.sv
package event_filt_pkg;

    localparam int CODE_W = 4;
    localparam int RUN_W  = 4;
    localparam int EXP_W  = 3;

    typedef struct packed {
        logic             bypass;
        logic [EXP_W-1:0] rate_exp;   // 0: every clock, k: every 2^k enables
        logic [RUN_W-1:0] need;       // samples in a row before a flip
    } filt_sel_t;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] cnt;
    } run_state_t;

    function automatic filt_sel_t decode_code(input logic [CODE_W-1:0] c);
        filt_sel_t s;
        s.bypass   = 1'b0;
        s.rate_exp = '0;
        s.need     = '0;
        case (c)
            4'd0:  s.bypass = 1'b1;
            4'd1:  s.need = 4'd2;
            4'd2:  s.need = 4'd4;
            4'd3:  s.need = 4'd8;
            4'd4:  begin s.rate_exp = 3'd1; s.need = 4'd6; end
            4'd5:  begin s.rate_exp = 3'd1; s.need = 4'd8; end
            4'd6:  begin s.rate_exp = 3'd2; s.need = 4'd6; end
            4'd7:  begin s.rate_exp = 3'd2; s.need = 4'd8; end
            4'd8:  begin s.rate_exp = 3'd3; s.need = 4'd6; end
            4'd9:  begin s.rate_exp = 3'd3; s.need = 4'd8; end
            4'd10: begin s.rate_exp = 3'd4; s.need = 4'd5; end
            4'd11: begin s.rate_exp = 3'd4; s.need = 4'd6; end
            4'd12: begin s.rate_exp = 3'd4; s.need = 4'd8; end
            4'd13: begin s.rate_exp = 3'd5; s.need = 4'd5; end
            4'd14: begin s.rate_exp = 3'd5; s.need = 4'd6; end
            default: begin s.rate_exp = 3'd5; s.need = 4'd8; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/efilt_sync.sv
module efilt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/efilt_tick.sv
module efilt_tick
    import event_filt_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             dts_en,
    input  logic [EXP_W-1:0] rate_exp,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb mask = DIV_W'((32'd1 << rate_exp) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst || clr)  div_q <= '0;
        else if (dts_en) div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (rate_exp == '0) tick = 1'b1;
        else                tick = !clr && dts_en && ((div_q & mask) == mask);
    end

    // R6: divided rates never sample without a dead-time pulse
    a_r6_no_tick_without_en: assert property (@(posedge clk) disable iff (rst)
        (rate_exp != '0 && !dts_en) |-> !tick);

    // R7: a code change restarts the divider
    a_r7_div_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> div_q == '0);
endmodule

// File: rtl/efilt_count.sv
module efilt_count
    import event_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bypass,
    input  logic             tick,
    input  logic             samp,
    input  logic [RUN_W-1:0] need,
    output logic             filt_o
);
    run_state_t st_q;
    logic [RUN_W-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (bypass) begin
            st_q.lvl <= samp;
            st_q.cnt <= '0;
        end else if (clr) begin
            st_q.cnt <= '0;
        end else if (tick) begin
            if (samp == st_q.lvl) begin
                st_q.cnt <= '0;
            end else if (cnt_inc >= need) begin
                st_q.lvl <= samp;
                st_q.cnt <= '0;
            end else begin
                st_q.cnt <= cnt_inc;
            end
        end
    end

    assign filt_o = st_q.lvl;

    // R2: pass-through copies the synchronised sample
    a_r2_bypass_copies: assert property (@(posedge clk) disable iff (rst)
        bypass |=> filt_o == $past(samp));

    // R3: the output flips only on a tick that completes a run
    a_r3_hold_unless_run_done: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !(tick && !clr && st_q.cnt + 1'b1 >= need)) |=> $stable(filt_o));

    // R4: a matching sample drops the partial run
    a_r4_match_clears: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !clr && tick && samp == filt_o) |=> st_q.cnt == '0);

    // R7: a code change drops the partial run
    a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> st_q.cnt == '0);

    // R5: the run never reaches the required length while held
    a_r5_cnt_below_need: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !clr) |-> st_q.cnt < need);
endmodule

// File: rtl/event_filt.sv
module event_filt
    import event_filt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic              dts_en,
    input  logic [CODE_W-1:0] filt_code,
    output logic              sig_out
);
    logic [CODE_W-1:0] code_q;
    logic              code_chg;
    filt_sel_t         sel;
    logic              samp;
    logic              tick;

    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= filt_code;
    end

    assign code_chg = (filt_code != code_q);
    assign sel      = decode_code(code_q);

    efilt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sig_in),
        .q_o (samp)
    );

    efilt_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clr      (code_chg),
        .dts_en   (dts_en),
        .rate_exp (sel.rate_exp),
        .tick     (tick)
    );

    efilt_count u_count (
        .clk    (clk),
        .rst    (rst),
        .clr    (code_chg),
        .bypass (sel.bypass),
        .tick   (tick),
        .samp   (samp),
        .need   (sel.need),
        .filt_o (sig_out)
    );

    // R1: the first cycle after reset shows a low output
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !sig_out);
endmodule

// File: tb/event_filt_tb.sv
module event_filt_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_in = 1'b0;
    logic       dts_en = 1'b0;
    logic [3:0] filt_code = 4'd0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int dts_mode = 1;        // 0 low, 1 every clock, 2 every other clock
    bit dts_ph = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    event_filt dut_i (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .dts_en    (dts_en),
        .filt_code (filt_code),
        .sig_out   (sig_out_w)
    );
    logic sig_out_w;

    always @(negedge clk) begin
        dts_ph <= ~dts_ph;
        case (dts_mode)
            0:       dts_en <= 1'b0;
            1:       dts_en <= 1'b1;
            default: dts_en <= ~dts_ph;
        endcase
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic settle(input bit lvl);
        sig_in = lvl;
        edges(300);
    endtask

    task automatic t_reset();
        sig_in = 1'b1;
        edges(4);
        chk(sig_out_w == 1'b0, "R1", sig_out_w, 0, "output in reset");
        rst = 1'b0;
        sig_in = 1'b0;
        chk(sig_out_w == 1'b0, "R1", sig_out_w, 0, "output after reset");
        edges(6);
        chk(sig_out_w == 1'b0, "R1", sig_out_w, 0, "code 0 idle output");
    endtask

    task automatic t_bypass();
        filt_code = 4'd0;
        settle(1'b0);
        sig_in = 1'b1;
        edges(2);
        chk(sig_out_w == 1'b0, "R2", sig_out_w, 0, "pass-through edge 2");
        edges(1);
        chk(sig_out_w == 1'b1, "R2", sig_out_w, 1, "pass-through edge 3");
        settle(1'b0);
        sig_in = 1'b1;
        edges(1);
        sig_in = 1'b0;
        edges(2);
        chk(sig_out_w == 1'b1, "R2", sig_out_w, 1, "short pulse shown");
        edges(1);
        chk(sig_out_w == 1'b0, "R2", sig_out_w, 0, "short pulse ends");
    endtask

    // measure the edge at which the output first follows a new level
    task automatic measure(input logic [3:0] code, input bit lvl, input int lo, input int hi, input string req);
        int idx;
        filt_code = code;
        settle(~lvl);
        chk(sig_out_w == ~lvl, req, sig_out_w, ~lvl, "settled level");
        sig_in = lvl;
        idx = 0;
        for (int i = 1; i <= hi + 5; i++) begin
            edges(1);
            if (idx == 0 && sig_out_w == lvl) idx = i;
        end
        chk(idx >= lo && idx <= hi, req, idx, hi, "flip edge");
    endtask

    task automatic t_short_runs();
        filt_code = 4'd1;
        settle(1'b0);
        sig_in = 1'b1; edges(1); sig_in = 1'b0;
        edges(12);
        chk(sig_out_w == 1'b0, "R3", sig_out_w, 0, "N=2 rejects 1-cycle run");
        filt_code = 4'd3;
        settle(1'b0);
        sig_in = 1'b1; edges(7); sig_in = 1'b0;
        edges(14);
        chk(sig_out_w == 1'b0, "R3", sig_out_w, 0, "N=8 rejects 7-cycle run");
        sig_in = 1'b1; edges(7);
        sig_in = 1'b0; edges(1);
        sig_in = 1'b1; edges(7);
        sig_in = 1'b0;
        edges(14);
        chk(sig_out_w == 1'b0, "R4", sig_out_w, 0, "gap of one sample restarts run");
    endtask

    task automatic t_dts_gate();
        filt_code = 4'd9;
        settle(1'b0);
        dts_mode = 0;
        sig_in = 1'b1;
        edges(300);
        chk(sig_out_w == 1'b0, "R6", sig_out_w, 0, "no enable, no flip");
        dts_mode = 1;
        edges(80);
        chk(sig_out_w == 1'b1, "R6", sig_out_w, 1, "flip after enable resumes");
    endtask

    task automatic t_code_change();
        filt_code = 4'd3;
        settle(1'b0);
        sig_in = 1'b1;
        edges(7);
        filt_code = 4'd2;
        edges(4);
        chk(sig_out_w == 1'b0, "R7", sig_out_w, 0, "run cleared, edge 11");
        edges(1);
        chk(sig_out_w == 1'b1, "R7", sig_out_w, 1, "flip at edge 12");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_bypass();
        // R3: per-clock codes, exact flip edge 2+N
        measure(4'd1, 1'b1, 4, 4, "R3");
        measure(4'd2, 1'b1, 6, 6, "R3");
        measure(4'd3, 1'b1, 10, 10, "R3");
        // R8: falling direction
        measure(4'd2, 1'b0, 6, 6, "R8");
        t_short_runs();
        // R5: divided codes, enable every clock (P=1)
        measure(4'd4, 1'b1, 3 + 5 * 2, 2 + 6 * 2, "R5");
        measure(4'd7, 1'b1, 3 + 7 * 4, 2 + 8 * 4, "R5");
        measure(4'd10, 1'b1, 3 + 4 * 16, 2 + 5 * 16, "R5");
        measure(4'd13, 1'b0, 3 + 4 * 32, 2 + 5 * 32, "R5");
        measure(4'd15, 1'b1, 3 + 7 * 32, 2 + 8 * 32, "R5");
        // R5: enable every other clock (P=2)
        dts_mode = 2;
        measure(4'd4, 1'b1, 3 + 5 * 4, 2 + 6 * 4, "R5");
        measure(4'd8, 1'b0, 3 + 5 * 16, 2 + 6 * 16, "R5");
        dts_mode = 1;
        t_dts_gate();
        t_code_change();
        done = 1'b1;
        finish_run();
    end
endmodule